// File: doc/BRIEF.md
# Multidrop Address Wake-Up Receiver

This block sits behind a UART deserialiser on a shared multidrop line and decides which decoded characters reach the CPU. Each incoming character carries eight data bits, a ninth type flag that marks it as an address or as data, and a framing-error flag. When multidrop operation is selected, the block watches every character on the line, even while the channel receiver is disabled. It wakes the CPU only for address characters: it loads the character, raises the ready indication and, if enabled, an interrupt. Software compares the held address against its own station number, which can be any of 256 values. It enables the receiver only when it wants the data block that follows.

Characters leave through a one-entry holding register. It is presented as a valid/ready stream: `out_valid` stays high while a character is held, and a cycle with `out_valid` and `out_ready` both high consumes it. The input side has no back-pressure, because a serial receiver cannot stall. A character that arrives while the holding register is full and not being consumed is lost, and the overrun flag is set. The held character is kept. Control pins (`cfg_multidrop`, `rx_enable`, `irq_enable`) are plain levels.

Top module: `mdw_wake_rx`

## Requirements
- R1: After reset, `out_valid`, `overrun` and `irq` are 0.
- R2: With `cfg_multidrop`=1 and `rx_enable`=0, a character with `in_addr_flag`=1 is loaded. On the cycle after its `in_valid` strobe, `out_valid`=1, `out_data` equals the character and `out_is_addr`=1.
- R3: With `cfg_multidrop`=1 and `rx_enable`=0, a character with `in_addr_flag`=0 is dropped. `out_valid`, `out_data` and `overrun` keep their values.
- R4: With `cfg_multidrop`=1 and `rx_enable`=1, every character is loaded, and `out_is_addr` equals its `in_addr_flag`.
- R5: A cycle with `out_valid`=1 and `out_ready`=1 and no new character leaves `out_valid`=0 on the next cycle, and clears `overrun`.
- R6: A character accepted while `out_valid`=1 and `out_ready`=0 sets `overrun`=1. The held `out_data` is unchanged.
- R7: If a character is accepted in the same cycle that the held one is consumed, the new character is loaded, `out_valid` stays 1 and `overrun` is 0.
- R8: `irq` is 1 exactly when `irq_enable`=1 and `out_valid`=1, in the same cycle.
- R9: `out_frame_err` carries the `in_frame_err` of the held character.
- R10: With `cfg_multidrop`=0, characters are dropped while `rx_enable`=0. While `rx_enable`=1 they are all loaded, with `out_is_addr`=0 whatever the type flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multidrop | input | 1 | 1 selects multidrop (address wake-up) operation |
| rx_enable | input | 1 | Channel receiver enable |
| irq_enable | input | 1 | Interrupt enable |
| in_valid | input | 1 | One-cycle strobe: a decoded character is present |
| in_data | input | DATA_W | Character data bits |
| in_addr_flag | input | 1 | Ninth bit: 1 address, 0 data |
| in_frame_err | input | 1 | Framing error on this character |
| out_valid | output | 1 | Holding register full (ready flag) |
| out_ready | input | 1 | Consumer reads the held character this cycle |
| out_data | output | DATA_W | Held character |
| out_is_addr | output | 1 | Held character is an address |
| out_frame_err | output | 1 | Held character had a framing error |
| overrun | output | 1 | A character was lost while the register was full |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default `DATA_W`=8 and the combinational interrupt (`IRQ_REG`=0). With these values, the whole 256-station address space can be swept: every address value is checked for wake-up and held-value integrity while a data character is being dropped. The framing-error and interrupt-enable values alternate across the sweep. Directed sequences then cover the enabled multidrop path, normal mode, overrun and the simultaneous consume-and-load case.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic [1:0] {
    ACC_NONE      = 2'd0,
    ACC_ADDR_ONLY = 2'd1,
    ACC_ALL       = 2'd2
  } acc_policy_e;

  function automatic acc_policy_e pick_policy(input logic multidrop, input logic rx_en);
    if (rx_en)          return ACC_ALL;
    else if (multidrop) return ACC_ADDR_ONLY;
    else                return ACC_NONE;
  endfunction
endpackage

// File: rtl/mdw_classify.sv
module mdw_classify
  import mdw_pkg::*;
(
  input  logic multidrop,
  input  logic rx_enable,
  input  logic in_valid,
  input  logic in_addr_flag,
  output logic accept,
  output logic tag_addr
);
  acc_policy_e policy;

  always_comb begin
    policy = pick_policy(multidrop, rx_enable);
    unique case (policy)
      ACC_ALL:       accept = in_valid;
      ACC_ADDR_ONLY: accept = in_valid & in_addr_flag;
      default:       accept = 1'b0;
    endcase
    tag_addr = multidrop & in_addr_flag;
  end
endmodule

// File: rtl/mdw_hold.sv
module mdw_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_is_addr,
  input  logic              load_fe,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q,
  output logic              is_addr_q,
  output logic              fe_q,
  output logic              overrun_q
);
  logic pop;
  logic store;

  always_comb begin
    pop   = full & take;
    store = load & (~full | pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      data_q    <= '0;
      is_addr_q <= 1'b0;
      fe_q      <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (store) begin
        full      <= 1'b1;
        data_q    <= load_data;
        is_addr_q <= load_is_addr;
        fe_q      <= load_fe;
        overrun_q <= 1'b0;
      end else if (load) begin
        overrun_q <= 1'b1;
      end else if (pop) begin
        full      <= 1'b0;
        overrun_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdw_wake_rx.sv
module mdw_wake_rx #(
  parameter int DATA_W  = 8,
  parameter bit IRQ_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_multidrop,
  input  logic              rx_enable,
  input  logic              irq_enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_addr_flag,
  input  logic              in_frame_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_addr,
  output logic              out_frame_err,
  output logic              overrun,
  output logic              irq
);
  logic accept;
  logic tag_addr;

  mdw_classify u_cls (
    .multidrop    (cfg_multidrop),
    .rx_enable    (rx_enable),
    .in_valid     (in_valid),
    .in_addr_flag (in_addr_flag),
    .accept       (accept),
    .tag_addr     (tag_addr)
  );

  mdw_hold #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_data    (in_data),
    .load_is_addr (tag_addr),
    .load_fe      (in_frame_err),
    .take         (out_ready),
    .full         (out_valid),
    .data_q       (out_data),
    .is_addr_q    (out_is_addr),
    .fe_q         (out_frame_err),
    .overrun_q    (overrun)
  );

  generate
    if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_enable & out_valid;
      end
      assign irq = irq_q;
    end else begin : g_irq_comb
      assign irq = irq_enable & out_valid;
    end
  endgenerate
endmodule

// File: rtl/mdw_wake_rx_chk.sv
module mdw_wake_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_multidrop,
  input logic              rx_enable,
  input logic              in_valid,
  input logic              in_addr_flag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overrun));

  p_addr_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multidrop && in_valid && in_addr_flag) |=> out_valid);

  p_data_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multidrop && !rx_enable && in_valid && !in_addr_flag && !out_ready)
      |=> ($stable(out_valid) && $stable(out_data) && $stable(overrun)));

  p_pop_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> (!out_valid && !overrun));

  p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_enable && out_valid && !out_ready)
      |=> (overrun && $stable(out_data) && out_valid));

  p_normal_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_multidrop && !rx_enable && !out_valid) |=> !out_valid);
endmodule

bind mdw_wake_rx mdw_wake_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_multidrop (cfg_multidrop),
  .rx_enable     (rx_enable),
  .in_valid      (in_valid),
  .in_addr_flag  (in_addr_flag),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .overrun       (overrun)
);

// File: tb/mdw_wake_rx_bench.sv
`timescale 1ns/1ps
module mdw_wake_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_multidrop = 1'b0, rx_enable = 1'b0, irq_enable = 1'b0;
  logic       in_valid = 1'b0, in_addr_flag = 1'b0, in_frame_err = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_is_addr, out_frame_err, overrun, irq;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  mdw_wake_rx u_mdw_wake_rx (
    .clk(clk), .rst_n(rst_n), .cfg_multidrop(cfg_multidrop), .rx_enable(rx_enable),
    .irq_enable(irq_enable), .in_valid(in_valid), .in_data(in_data),
    .in_addr_flag(in_addr_flag), .in_frame_err(in_frame_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_is_addr(out_is_addr),
    .out_frame_err(out_frame_err), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One character strobe; outputs are sampled at the following negedge.
  task automatic send(input logic [7:0] d, input logic a, input logic fe, input logic rd);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_addr_flag = a; in_frame_err = fe; out_ready = rd;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && overrun == 0 && irq == 0, "R1 reset", {out_valid, overrun, irq}, 0);
    rst_n = 1'b1;

    // Sweep of all 256 station addresses with the receiver disabled.
    cfg_multidrop = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a;
      a = 8'(v);
      irq_enable = a[1];
      send(a, 1'b1, a[0], 1'b0);
      chk(out_valid == 1 && out_is_addr == 1, "R2 wake", {out_valid, out_is_addr}, 3);
      chk(out_data == a, "R2 data", out_data, a);
      chk(out_frame_err == a[0], "R9 frame err", out_frame_err, a[0]);
      chk(irq == a[1], "R8 irq", irq, a[1]);
      send(a ^ 8'h5A, 1'b0, 1'b1, 1'b0);
      chk(out_valid == 1 && out_data == a && overrun == 0, "R3 data dropped",
          {out_valid, out_data, overrun}, {1'b1, a, 1'b0});
      pop();
      chk(out_valid == 0 && irq == 0, "R5 pop", {out_valid, irq}, 0);
    end

    // R3: data while empty and disabled stays invisible.
    send(8'h33, 1'b0, 1'b0, 1'b0);
    chk(out_valid == 0, "R3 empty drop", out_valid, 0);

    // R4: receiver enabled, both types loaded.
    rx_enable = 1'b1; irq_enable = 1'b0;
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    chk(out_valid && out_data == 8'hC3 && out_is_addr == 0, "R4 data loaded",
        {out_valid, out_data, out_is_addr}, {1'b1, 8'hC3, 1'b0});
    chk(irq == 0, "R8 irq masked", irq, 0);
    // R6: overrun keeps old character.
    send(8'h99, 1'b1, 1'b0, 1'b0);
    chk(overrun == 1 && out_data == 8'hC3 && out_is_addr == 0, "R6 overrun",
        {overrun, out_data, out_is_addr}, {1'b1, 8'hC3, 1'b0});
    // R7: consume and load in the same cycle.
    send(8'h7E, 1'b1, 1'b1, 1'b1);
    chk(out_valid && out_data == 8'h7E && out_is_addr && out_frame_err && !overrun,
        "R7 pop+load", {out_valid, out_data, out_is_addr, out_frame_err, overrun},
        {1'b1, 8'h7E, 1'b1, 1'b1, 1'b0});
    chk(out_is_addr == 1, "R4 addr tag", out_is_addr, 1);
    // R5: overrun cleared by consume.
    send(8'h11, 1'b0, 1'b0, 1'b0);
    chk(overrun == 1, "R6 overrun again", overrun, 1);
    pop();
    chk(out_valid == 0 && overrun == 0, "R5 pop clears overrun", {out_valid, overrun}, 0);

    // R10: normal mode.
    cfg_multidrop = 1'b0; rx_enable = 1'b0;
    send(8'hA5, 1'b1, 1'b0, 1'b0);
    chk(out_valid == 0, "R10 disabled drops addr", out_valid, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    chk(out_valid == 0, "R10 disabled drops data", out_valid, 0);
    rx_enable = 1'b1;
    send(8'hE1, 1'b1, 1'b0, 1'b0);
    chk(out_valid && out_data == 8'hE1 && out_is_addr == 0, "R10 enabled loads",
        {out_valid, out_data, out_is_addr}, {1'b1, 8'hE1, 1'b0});
    pop();

    finish_run();
  end
endmodule